// File: doc/BRIEF.md
# Sequential Sector Erase Engine

This block erases a set of flash sectors one at a time. A start pulse captures two bitmaps: the sectors chosen for erasure and the sectors under write protection. The engine then walks the chosen, unprotected sectors from the lowest index upward. Each sector is first programmed to all zeros and checked, and then receives erase pulses, each followed by an erased-state check, until the check passes.

All array work goes through a request/acknowledge port that carries an operation code and a sector index. The cell array and the pulse circuits sit behind that port and lie outside the block. While the engine runs it reports busy, and a status bit flips on every status read. A one-cycle done pulse marks the return to read mode. If too many erase pulses are needed, or if the zero pattern does not verify, the error flag is set. If none of the chosen sectors can be erased, the engine makes no array request and waits for a fixed number of cycles before it finishes.

Top module: `sec_erase_seq`

## Requirements
- R1: The engine takes `start` only while it is in read mode, and it captures `sel_map` and `prot_map` at that edge. A `start` pulse while busy has no effect on which sectors are erased.
- R2: The engine works on one sector at a time, in ascending index order. Every request names a sector that is still waiting to be erased.
- R3: A protected sector gets no array operation, even when it is selected. All other selected sectors are still erased.
- R4: For each sector, the engine first issues preprogram (`op_code` 2'b00) and then verify-zero (2'b10). If verify-zero fails, the engine sets `err`, finishes, and sends no erase pulse to that sector.
- R5: After a passing verify-zero, the engine issues erase pulse (2'b01) and then verify-erased (2'b11). It repeats this pair until verify-erased passes.
- R6: A sector receives at most PULSE_MAX erase pulses. If verify-erased still fails after the last allowed pulse, the engine sets `err`, finishes, and leaves the higher sectors untouched. `err` clears on the next accepted start.
- R7: If no selected sector is unprotected, the engine makes no request. `done` rises in the (DWELL_CYC+1)-th cycle after the start edge.
- R8: `done` is high for exactly one cycle. In that cycle `busy` and `op_req` are low. `read_mode` is high exactly when `busy` is low.
- R9: Each `stat_rd` strobe while busy inverts `toggle_bit`. A strobe in read mode leaves it unchanged.
- R10: Asserting `rst_n` low at once clears `busy` and `op_req` and sets `read_mode`, even in the middle of an operation.
- R11: A request holds its `op_code` and `op_sect` stable until `op_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an erase run |
| sel_map | input | NUM_SECT | Sectors selected for erasure |
| prot_map | input | NUM_SECT | Write-protected sectors |
| op_req | output | 1 | Array operation request |
| op_code | output | 2 | 00 preprogram, 01 erase pulse, 10 verify zero, 11 verify erased |
| op_sect | output | SW | Sector index of the request |
| op_ack | input | 1 | Array operation complete |
| op_pass | input | 1 | Verify outcome, valid with `op_ack` |
| stat_rd | input | 1 | Status read strobe |
| toggle_bit | output | 1 | Flips per status read while busy |
| busy | output | 1 | Engine running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Run ended on a failed verify or the pulse limit |
| read_mode | output | 1 | Array readable (engine idle) |

## Verification
The bench builds the engine with four sectors, a limit of three erase pulses and a dwell of twenty cycles. With only four sectors, all 256 pairings of the selection and protection bitmaps can be run, so every ordering, every skip pattern and the empty-work dwell are covered. A pulse limit of three lets a sector that needs one more pulse hit the error path in a few cycles. The short dwell lets the bench check the exact cycle of the done pulse.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_PREP,
    ST_PVFY,
    ST_ERASE,
    ST_EVFY,
    ST_DWELL,
    ST_FIN
  } sec_st_t;

  localparam logic [1:0] OP_PREP  = 2'b00;
  localparam logic [1:0] OP_PULSE = 2'b01;
  localparam logic [1:0] OP_VZERO = 2'b10;
  localparam logic [1:0] OP_VONES = 2'b11;

endpackage

// File: rtl/sec_pick.sv
// Lowest-index finder over the pending sector map.
module sec_pick #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic [N-1:0]  map,
  output logic          found,
  output logic [SW-1:0] idx
);

  always_comb begin
    found = |map;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (map[i]) idx = SW'(i);
    end
  end

endmodule

// File: rtl/sec_tmr.sv
// Clearable up-counter used for pulse counting and the dwell wait.
module sec_tmr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/sec_tgl.sv
// Status toggle: flips on each read strobe while the engine runs.
module sec_tgl (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rd,
  output logic q
);

  logic q_en;

  assign q_en = run & rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= ~q;
  end

endmodule

// File: rtl/sec_erase_seq.sv
module sec_erase_seq #(
  parameter int NUM_SECT  = 8,
  parameter int PULSE_MAX = 16,
  parameter int DWELL_CYC = 5000,
  localparam int SW  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int PW  = $clog2(PULSE_MAX + 1),
  localparam int DWW = $clog2(DWELL_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NUM_SECT-1:0] sel_map,
  input  logic [NUM_SECT-1:0] prot_map,
  output logic                op_req,
  output logic [1:0]          op_code,
  output logic [SW-1:0]       op_sect,
  input  logic                op_ack,
  input  logic                op_pass,
  input  logic                stat_rd,
  output logic                toggle_bit,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                read_mode
);
  import sec_erase_pkg::*;

  // reset: asserted at once, released through two flops
  logic rs_q1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rs_q1  <= 1'b1;
      rst_sn <= rs_q1;
    end
  end

  sec_st_t              st_q, st_d;
  logic [NUM_SECT-1:0]  pend_q, pend_d;
  logic [SW-1:0]        cur_q, cur_d;
  logic                 err_q, err_d;
  logic                 pick_found;
  logic [SW-1:0]        pick_idx;
  logic [PW-1:0]        pulse_cnt;
  logic [DWW-1:0]       dwell_cnt;
  logic                 pulse_clr, pulse_inc, dwell_clr, dwell_inc;
  logic [NUM_SECT-1:0]  work_map;

  assign work_map = sel_map & ~prot_map;

  sec_pick #(.N(NUM_SECT), .SW(SW)) u_pick (
    .map   (pend_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  sec_tmr #(.W(PW)) u_pulse (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (pulse_clr),
    .inc   (pulse_inc),
    .cnt   (pulse_cnt)
  );

  sec_tmr #(.W(DWW)) u_dwell (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (dwell_clr),
    .inc   (dwell_inc),
    .cnt   (dwell_cnt)
  );

  sec_tgl u_tgl (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   (busy),
    .rd    (stat_rd),
    .q     (toggle_bit)
  );

  // next state
  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    cur_d     = cur_q;
    err_d     = err_q;
    pulse_clr = 1'b0;
    pulse_inc = 1'b0;
    dwell_clr = 1'b0;
    dwell_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        dwell_clr = 1'b1;
        if (start) begin
          pend_d = work_map;
          err_d  = 1'b0;
          st_d   = (|work_map) ? ST_PICK : ST_DWELL;
        end
      end
      ST_PICK: begin
        pulse_clr = 1'b1;
        if (pick_found) begin
          cur_d = pick_idx;
          st_d  = ST_PREP;
        end else begin
          st_d  = ST_FIN;
        end
      end
      ST_PREP: begin
        if (op_ack) st_d = ST_PVFY;
      end
      ST_PVFY: begin
        if (op_ack) begin
          if (op_pass) begin
            st_d = ST_ERASE;
          end else begin
            err_d = 1'b1;
            st_d  = ST_FIN;
          end
        end
      end
      ST_ERASE: begin
        if (op_ack) begin
          pulse_inc = 1'b1;
          st_d      = ST_EVFY;
        end
      end
      ST_EVFY: begin
        if (op_ack) begin
          if (op_pass) begin
            pend_d[cur_q] = 1'b0;
            st_d          = ST_PICK;
          end else if (pulse_cnt >= PW'(PULSE_MAX)) begin
            err_d = 1'b1;
            st_d  = ST_FIN;
          end else begin
            st_d  = ST_ERASE;
          end
        end
      end
      ST_DWELL: begin
        dwell_inc = 1'b1;
        if (dwell_cnt == DWW'(DWELL_CYC - 1)) st_d = ST_FIN;
      end
      ST_FIN: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      cur_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      cur_q  <= cur_d;
      err_q  <= err_d;
    end
  end

  // outputs
  always_comb begin
    op_req  = 1'b0;
    op_code = OP_PREP;
    unique case (st_q)
      ST_PREP:  begin op_req = 1'b1; op_code = OP_PREP;  end
      ST_PVFY:  begin op_req = 1'b1; op_code = OP_VZERO; end
      ST_ERASE: begin op_req = 1'b1; op_code = OP_PULSE; end
      ST_EVFY:  begin op_req = 1'b1; op_code = OP_VONES; end
      default:  begin op_req = 1'b0; op_code = OP_PREP;  end
    endcase
  end

  assign op_sect   = cur_q;
  assign busy      = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign done      = (st_q == ST_FIN);
  assign err       = err_q;
  assign read_mode = ~busy;

endmodule

// File: rtl/sec_erase_chk.sv
module sec_erase_chk #(
  parameter int NUM_SECT  = 8,
  parameter int PULSE_MAX = 16,
  parameter int SW        = 3,
  parameter int PW        = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_req,
  input logic [1:0]          op_code,
  input logic [SW-1:0]       op_sect,
  input logic                op_ack,
  input logic                stat_rd,
  input logic                toggle_bit,
  input logic                busy,
  input logic                done,
  input logic [NUM_SECT-1:0] pend_q,
  input logic [PW-1:0]       pulse_cnt
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !op_req));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !op_ack) |=> (op_req && $stable(op_sect) && $stable(op_code)));

  // R2
  sect_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> pend_q[op_sect]);

  // R6
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && op_code == 2'b01) |-> (pulse_cnt < PW'(PULSE_MAX)));

  // R9
  tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stat_rd) |=> (toggle_bit != $past(toggle_bit)));

  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> busy);

endmodule

bind sec_erase_seq sec_erase_chk #(
  .NUM_SECT  (NUM_SECT),
  .PULSE_MAX (PULSE_MAX),
  .SW        (SW),
  .PW        (PW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .op_req     (op_req),
  .op_code    (op_code),
  .op_sect    (op_sect),
  .op_ack     (op_ack),
  .stat_rd    (stat_rd),
  .toggle_bit (toggle_bit),
  .busy       (busy),
  .done       (done),
  .pend_q     (pend_q),
  .pulse_cnt  (pulse_cnt)
);

// File: tb/sec_erase_seq_tb.sv
module sec_erase_seq_tb_top;
  localparam int NS = 4;
  localparam int PM = 3;
  localparam int DW = 20;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [NS-1:0] sel_map, prot_map;
  logic          op_req, op_ack, op_pass, stat_rd;
  logic [1:0]    op_code;
  logic [1:0]    op_sect;
  logic          toggle_bit, busy, done, err, read_mode;

  int n_chk, n_bad;
  int need   [NS];
  bit pvfail [NS];
  int pulses [NS];
  int ppcnt  [NS];
  int log_s  [16];
  int log_n;
  int last_s;
  bit saw_req;
  int run_cyc;
  bit timeout;

  sec_erase_seq #(.NUM_SECT(NS), .PULSE_MAX(PM), .DWELL_CYC(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_map(sel_map),
    .prot_map(prot_map), .op_req(op_req), .op_code(op_code),
    .op_sect(op_sect), .op_ack(op_ack), .op_pass(op_pass),
    .stat_rd(stat_rd), .toggle_bit(toggle_bit), .busy(busy),
    .done(done), .err(err), .read_mode(read_mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // array model answering requests one cycle later
  always @(negedge clk) begin
    if (!rst_n) begin
      op_ack <= 1'b0;
    end else if (op_req && !op_ack) begin
      int s;
      s = int'(op_sect);
      saw_req = 1'b1;
      if (s != last_s) begin
        log_s[log_n % 16] = s;
        log_n++;
        last_s = s;
      end
      op_pass <= 1'b0;
      case (op_code)
        2'b00: ppcnt[s]++;
        2'b01: pulses[s]++;
        2'b10: op_pass <= (ppcnt[s] > 0) && !pvfail[s];
        default: op_pass <= (pulses[s] >= need[s]);
      endcase
      op_ack <= 1'b1;
    end else begin
      op_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NS; i++) begin
      pulses[i] = 0;
      ppcnt[i]  = 0;
    end
    log_n   = 0;
    last_s  = -1;
    saw_req = 1'b0;
  endtask

  // start a run and wait for done; run_cyc = negedge count at done
  task automatic run(input logic [NS-1:0] s, input logic [NS-1:0] p);
    clear_model();
    @(negedge clk);
    sel_map = s; prot_map = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_cyc = 1;
    timeout = 1'b0;
    while (!done && run_cyc < 3000) begin
      @(negedge clk);
      run_cyc++;
    end
    if (!done) begin
      timeout = 1'b1;
      chk(1'b0, "watchdog", run_cyc, 0);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    start = 0; sel_map = 0; prot_map = 0; stat_rd = 0;
    op_pass = 0;
    for (int i = 0; i < NS; i++) begin
      need[i] = (i % 3) + 1;
      pvfail[i] = 0;
    end
    clear_model();
    rst_n = 0;
    #1;
    chk(!busy && !op_req && read_mode && !done && !err, "R10 reset state",
        int'(busy), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // exhaustive sweep of selection and protection maps
    for (int sv = 0; sv < 16; sv++) begin
      for (int pv = 0; pv < 16; pv++) begin
        logic [NS-1:0] wk;
        bit asc;
        int tmask;
        wk = 4'(sv) & ~4'(pv);
        run(4'(sv), 4'(pv));
        if (timeout) continue;
        chk(!busy && read_mode, "R8 idle at done", int'(busy), 0);
        chk(err == 1'b0, "R6 no error", int'(err), 0);
        tmask = 0;
        for (int i = 0; i < NS; i++) begin
          if (ppcnt[i] > 0) tmask |= (1 << i);
        end
        chk(tmask == int'(wk), "R3 touched set", tmask, int'(wk));
        asc = 1'b1;
        for (int k = 1; k < log_n; k++) begin
          if (log_s[k] <= log_s[k-1]) asc = 1'b0;
        end
        chk(asc && log_n == $countones(wk), "R2 ascending", log_n,
            $countones(wk));
        for (int i = 0; i < NS; i++) begin
          if (wk[i]) chk(pulses[i] == need[i] && ppcnt[i] == 1, "R5 pulses",
                         pulses[i], need[i]);
        end
        if (wk == 0)
          chk(run_cyc == DW + 1 && !saw_req, "R7 dwell", run_cyc, DW + 1);
        @(negedge clk);
        chk(!done, "R8 one cycle", int'(done), 0);
      end
    end

    // pulse limit exceeded on sector 1
    need[1] = PM + 1;
    run(4'b1111, 4'b0000);
    chk(err == 1'b1, "R6 error set", int'(err), 1);
    chk(pulses[1] == PM, "R6 pulse count", pulses[1], PM);
    chk(ppcnt[2] == 0 && ppcnt[3] == 0, "R6 stop", ppcnt[2] + ppcnt[3], 0);
    need[1] = 2;

    // preprogram verify failure on sector 2
    pvfail[2] = 1'b1;
    run(4'b1100, 4'b0000);
    chk(err == 1'b1, "R4 error set", int'(err), 1);
    chk(pulses[2] == 0 && ppcnt[3] == 0, "R4 no pulse", pulses[2], 0);
    pvfail[2] = 1'b0;
    run(4'b0001, 4'b0000);
    chk(err == 1'b0, "R6 err cleared", int'(err), 0);

    // start while busy ignored
    clear_model();
    @(negedge clk);
    sel_map = 4'b0001; prot_map = 0; start = 1;
    @(negedge clk);
    sel_map = 4'b1000;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk(ppcnt[3] == 0 && ppcnt[0] == 1, "R1 start ignored", ppcnt[3], 0);

    // toggle bit
    need[0] = 3;
    @(negedge clk);
    sel_map = 4'b0001; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    begin
      logic t0;
      t0 = toggle_bit;
      stat_rd = 1;
      @(negedge clk);
      stat_rd = 0;
      chk(toggle_bit == ~t0, "R9 flip", int'(toggle_bit), int'(~t0));
      stat_rd = 1;
      @(negedge clk);
      stat_rd = 0;
      chk(toggle_bit == t0, "R9 flip back", int'(toggle_bit), int'(t0));
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    begin
      logic t1;
      t1 = toggle_bit;
      stat_rd = 1;
      @(negedge clk);
      stat_rd = 0;
      @(negedge clk);
      chk(toggle_bit == t1, "R9 idle hold", int'(toggle_bit), int'(t1));
    end

    // reset in mid-run
    @(negedge clk);
    sel_map = 4'b1111; prot_map = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R10 running", int'(busy), 1);
    rst_n = 0;
    #1;
    chk(!busy && !op_req && read_mode, "R10 abort", int'(busy), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run(4'b0110, 4'b0010);
    chk(ppcnt[2] == 1 && ppcnt[1] == 0, "R3 after reset", ppcnt[1], 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule